// File: doc/BRIEF.md
# Watchdog Timer with Secure Clear

This block is a 16-bit down-counting timer driven by a slow (nominally 32 kHz) tick enable, used to catch software lock-up. Software sets a reload value and a control word, then must keep retriggering the timer with clear writes before the count runs out. If the count runs out, the block either pulses a system reset request or raises a non-maskable interrupt level, depending on the control word.

In secure mode a clear write is accepted only when its data equals the next value of an 8-bit pseudo-random sequence that the hardware keeps. The sequence starts from a seed that software can load, and it moves one step after each accepted clear. A clear with any other value counts as a timeout straight away. Once the watchdog function is switched on, the control word, the reload value and the seed are frozen until the next system reset. With the watchdog function off, the same counter serves as a plain periodic timer that pulses an interrupt each time it wraps.

Top module: `wdt_guard`

## Requirements
- R1: After reset, count_o is 0xFFFF, the reload value is 0xFFFF, rst_req_o, nmi_o and tmr_irq_o are 0, the control word is 0 and the expected secure-clear value is 0x5A.
- R2: While the run bit (cfg_data bit 0) is set, each cycle with tick_i high and no other reload cause lowers count_o by one. While run is clear, tick_i has no effect on count_o.
- R3: An accepted control write loads count_o from the reload value held before that cycle. A reload write changes only the stored reload value, not count_o.
- R4: A tick while count_o is 0 is a timeout and count_o takes the reload value. With the watchdog bit (cfg_data bit 1) clear, a timeout drives tmr_irq_o high for exactly the next cycle.
- R5: In watchdog mode with the action bit (cfg_data bit 3) clear, a timeout drives rst_req_o high for exactly the next cycle.
- R6: In watchdog mode with the action bit set, a timeout sets nmi_o, and nmi_o stays set until an accepted clear write.
- R7: When secure mode is off, a clear write while running accepts any data, loads count_o from the reload value and clears nmi_o. A clear write in the same cycle as a tick wins: count_o is reloaded, not decremented.
- R8: In secure mode (cfg_data bit 2, with the watchdog bit set) a clear is accepted only if clr_data equals the expected value. Each accepted clear advances the expected value s to {s[6:0], s[7]^s[5]^s[4]^s[3]}.
- R9: In secure mode, a clear with a wrong value is an immediate timeout with the configured action, reloads count_o, and leaves the expected value unchanged.
- R10: While run and watchdog bits are both set, writes to the control word, the reload value and the seed are ignored until rst_n is asserted.
- R11: A seed write stores seed_data as the expected value, except that a seed of 0x00 is stored as 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable from the 32 kHz time base |
| cfg_we | input | 1 | Control word write strobe |
| cfg_data | input | 4 | Control word: bit0 run, bit1 watchdog, bit2 secure, bit3 action (1 = NMI, 0 = reset) |
| load_we | input | 1 | Reload value write strobe |
| load_data | input | 16 | Reload value |
| seed_we | input | 1 | Secure sequence seed write strobe |
| seed_data | input | 8 | Seed value |
| clr_we | input | 1 | Clear (retrigger) write strobe |
| clr_data | input | 8 | Clear data, compared in secure mode |
| count_o | output | 16 | Current count |
| rst_req_o | output | 1 | One-cycle system reset request |
| nmi_o | output | 1 | Non-maskable interrupt level |
| tmr_irq_o | output | 1 | One-cycle timer interrupt in general-purpose mode |

## Verification
The counter is run in general-purpose mode with spaced ticks, with ticks while stopped, and with clears landing on the same cycle as a tick, which separates the decrement, hold and reload priorities. Watchdog mode is driven to expiry under both actions, so a missing reset pulse and a missing or early-dropping NMI level show up as different mismatches. Secure mode is fed the correct chain of sequence values from a zero seed and from the reset seed, then a wrong value followed by the still-expected one, which tells apart a sequence that advances on rejection from one that stays put. Writes attempted after the lock show whether control, reload or seed leak through.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  localparam int SEQ_W = 8;
  localparam logic [SEQ_W-1:0] SEQ_RST = 8'h5A;

  typedef struct packed {
    logic nmi_sel;
    logic secure;
    logic wd_mode;
    logic run;
  } wdt_ctrl_t;

  localparam int CFG_W = $bits(wdt_ctrl_t);

  function automatic logic [SEQ_W-1:0] seq_step(input logic [SEQ_W-1:0] s);
    return {s[SEQ_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [SEQ_W-1:0] seed_fix(input logic [SEQ_W-1:0] d);
    return (d == '0) ? {{(SEQ_W-1){1'b0}}, 1'b1} : d;
  endfunction

endpackage

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_guard_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_W-1:0]     cfg_data,
  input  logic                 load_we,
  input  logic [CNT_W-1:0]     load_data,
  input  logic                 seed_we,
  output wdt_ctrl_t            ctrl,
  output logic [CNT_W-1:0]     load_val,
  output logic                 locked,
  output logic                 cfg_wr_ok,
  output logic                 seed_wr_ok
);

  assign locked     = ctrl.run & ctrl.wd_mode;
  assign cfg_wr_ok  = cfg_we & ~locked;
  assign seed_wr_ok = seed_we & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      load_val <= '1;
    end else begin
      if (cfg_wr_ok)           ctrl     <= wdt_ctrl_t'(cfg_data);
      if (load_we && !locked)  load_val <= load_data;
    end
  end

  AST_LOCK_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked && $stable(ctrl)); // R10
  AST_LOCK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(load_val)); // R10

endmodule

// File: rtl/wdt_seq.sv
module wdt_seq
  import wdt_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_wr,
  input  logic [SEQ_W-1:0] seed_data,
  input  logic [SEQ_W-1:0] clr_data,
  input  logic             advance,
  output logic             match
);

  logic [SEQ_W-1:0] expect_q;

  assign match = (clr_data == expect_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       expect_q <= SEQ_RST;
    else if (seed_wr) expect_q <= seed_fix(seed_data);
    else if (advance) expect_q <= seq_step(expect_q);
  end

  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance && !seed_wr |=> $stable(expect_q)); // R9
  AST_SEQ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expect_q != '0); // R11

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             reload_req,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire_evt
);

  assign expire_evt = run & tick & ~reload_req & (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '1;
    else if (reload_req)       count <= load_val;
    else if (expire_evt)       count <= load_val;
    else if (run && tick)      count <= count - 1'b1;
  end

  AST_TICK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick && !reload_req && count != '0 |=> count == $past(count) - 1'b1); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !reload_req |=> $stable(count)); // R2

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_data,
  input  logic             seed_we,
  input  logic [SEQ_W-1:0] seed_data,
  input  logic             clr_we,
  input  logic [SEQ_W-1:0] clr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             rst_req_o,
  output logic             nmi_o,
  output logic             tmr_irq_o
);

  wdt_ctrl_t        ctrl;
  logic [CNT_W-1:0] load_val;
  logic             locked, cfg_wr_ok, seed_wr_ok;
  logic             match, armed, clr_ok, clr_bad;
  logic             expire_evt, timeout_any, reload_req;

  wdt_cfg #(.CNT_W(CNT_W)) i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .load_we(load_we), .load_data(load_data), .seed_we(seed_we),
    .ctrl(ctrl), .load_val(load_val), .locked(locked),
    .cfg_wr_ok(cfg_wr_ok), .seed_wr_ok(seed_wr_ok)
  );

  // secure checking is live only when the watchdog is armed
  assign armed   = ctrl.run & ctrl.wd_mode & ctrl.secure;
  assign clr_ok  = clr_we & ctrl.run & ~cfg_wr_ok & (~armed | match);
  assign clr_bad = clr_we & armed & ~match;

  wdt_seq i_seq (
    .clk(clk), .rst_n(rst_n), .seed_wr(seed_wr_ok), .seed_data(seed_data),
    .clr_data(clr_data), .advance(clr_ok & armed), .match(match)
  );

  assign reload_req = cfg_wr_ok | clr_ok | clr_bad;

  wdt_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(tick_i),
    .reload_req(reload_req), .load_val(load_val),
    .count(count_o), .expire_evt(expire_evt)
  );

  assign timeout_any = expire_evt | clr_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_o <= 1'b0;
      nmi_o     <= 1'b0;
      tmr_irq_o <= 1'b0;
    end else begin
      rst_req_o <= timeout_any & ctrl.wd_mode & ~ctrl.nmi_sel;
      tmr_irq_o <= timeout_any & ~ctrl.wd_mode;
      if (timeout_any && ctrl.wd_mode && ctrl.nmi_sel) nmi_o <= 1'b1;
      else if (clr_ok)                                 nmi_o <= 1'b0;
    end
  end

  AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o && !clr_ok |=> nmi_o); // R6
  AST_NMI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok |=> !nmi_o); // R7
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req_o, tmr_irq_o})); // R4
  AST_BAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_bad && !ctrl.nmi_sel |=> rst_req_o); // R9

endmodule

// File: tb/test_wdt_guard.sv
module test_wdt_guard;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i = 0, cfg_we = 0, load_we = 0, seed_we = 0, clr_we = 0;
  logic [3:0]  cfg_data = 0;
  logic [15:0] load_data = 0;
  logic [7:0]  seed_data = 0, clr_data = 0;
  logic [15:0] count_o;
  logic        rst_req_o, nmi_o, tmr_irq_o;

  always #10 clk = ~clk;

  wdt_guard i_wdt_guard (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .load_we(load_we), .load_data(load_data), .seed_we(seed_we), .seed_data(seed_data),
    .clr_we(clr_we), .clr_data(clr_data), .count_o(count_o), .rst_req_o(rst_req_o),
    .nmi_o(nmi_o), .tmr_irq_o(tmr_irq_o)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // bench-side sequence step, written as a bit-count parity
  function automatic logic [7:0] nxt(input logic [7:0] s);
    int fb;
    fb = $countones(s & 8'b1011_1000) % 2;
    return ((s << 1) | 8'(fb)) & 8'hFF;
  endfunction

  // behavioural reference model
  logic [15:0] m_cnt, m_load;
  logic [7:0]  m_seq;
  logic [3:0]  m_ctrl, m_ctrl_n;
  logic        m_rst, m_nmi, m_irq;
  bit          trip, good, lock;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 16'hFFFF; m_load = 16'hFFFF; m_seq = 8'h5A; m_ctrl = 0;
      m_rst = 0; m_nmi = 0; m_irq = 0;
    end else begin
      lock = m_ctrl[0] && m_ctrl[1];
      trip = 0; good = 0; m_rst = 0; m_irq = 0; m_ctrl_n = m_ctrl;
      if (cfg_we && !lock) begin
        m_cnt = m_load; m_ctrl_n = cfg_data;
      end else if (m_ctrl[0] && clr_we) begin
        m_cnt = m_load;
        if (m_ctrl[1] && m_ctrl[2] && clr_data != m_seq) trip = 1;
        else begin
          good = 1;
          if (m_ctrl[1] && m_ctrl[2]) m_seq = nxt(m_seq);
        end
      end else if (m_ctrl[0] && tick_i) begin
        if (m_cnt == 0) begin trip = 1; m_cnt = m_load; end
        else m_cnt = m_cnt - 1;
      end
      if (trip) begin
        if (!m_ctrl[1]) m_irq = 1;
        else if (m_ctrl[3]) m_nmi = 1;
        else m_rst = 1;
      end else if (good) m_nmi = 0;
      if (load_we && !lock) m_load = load_data;
      if (seed_we && !lock) m_seq = (seed_data == 0) ? 8'h01 : seed_data;
      m_ctrl = m_ctrl_n;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk({cur_req, " count"}, 32'(count_o), 32'(m_cnt));
      chk({cur_req, " rst_req"}, 32'(rst_req_o), 32'(m_rst));
      chk({cur_req, " nmi"}, 32'(nmi_o), 32'(m_nmi));
      chk({cur_req, " irq"}, 32'(tmr_irq_o), 32'(m_irq));
    end
  end

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask
  task automatic wr_cfg(input logic [3:0] d);
    cfg_we = 1; cfg_data = d; @(negedge clk); cfg_we = 0;
  endtask
  task automatic wr_load(input logic [15:0] d);
    load_we = 1; load_data = d; @(negedge clk); load_we = 0;
  endtask
  task automatic wr_seed(input logic [7:0] d);
    seed_we = 1; seed_data = d; @(negedge clk); seed_we = 0;
  endtask
  task automatic clr(input logic [7:0] d);
    clr_we = 1; clr_data = d; @(negedge clk); clr_we = 0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1; @(negedge clk); tick_i = 0; @(negedge clk);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  logic [7:0] s;

  initial begin
    // R1 reset state
    cur_req = "R1";
    do_reset();
    chk("R1 count", 32'(count_o), 32'hFFFF);
    chk("R1 outputs", 32'({rst_req_o, nmi_o, tmr_irq_o}), 0);

    // R2 R3 general-purpose counting and hold
    cur_req = "R3";
    wr_load(16'd5);
    chk("R3 load write leaves count", 32'(count_o), 32'hFFFF);
    wr_cfg(4'b0001);
    chk("R3 cfg reloads", 32'(count_o), 5);
    cur_req = "R2";
    ticks(3);
    chk("R2 decrement", 32'(count_o), 2);
    wr_cfg(4'b0000);
    ticks(4);
    chk("R2 stopped hold", 32'(count_o), 5);

    // R4 timer wrap
    cur_req = "R4";
    wr_cfg(4'b0001);
    ticks(5);
    chk("R4 at zero", 32'(count_o), 0);
    tick_i = 1; @(negedge clk); tick_i = 0;
    chk("R4 irq pulse", 32'(tmr_irq_o), 1);
    chk("R4 reload", 32'(count_o), 5);
    @(negedge clk);
    chk("R4 irq one cycle", 32'(tmr_irq_o), 0);

    // R7 clear in general-purpose mode
    cur_req = "R7";
    ticks(2);
    clr(8'h33);
    chk("R7 gp clear", 32'(count_o), 5);

    // R8 R9 R11 R5 R10 secure watchdog with reset action
    do_reset();
    cur_req = "R11";
    wr_load(16'd10);
    wr_seed(8'h00);
    wr_cfg(4'b0111);
    cur_req = "R8";
    ticks(3);
    clr(8'h01);
    chk("R11 zero seed became 01", 32'(count_o), 10);
    chk("R8 no reset on good clear", 32'(rst_req_o), 0);
    s = nxt(8'h01);
    ticks(2);
    clr(s);
    chk("R8 second clear", 32'(count_o), 10);
    cur_req = "R9";
    ticks(2);
    clr(s ^ 8'h55);
    chk("R9 wrong value trips", 32'(rst_req_o), 1);
    chk("R9 reload", 32'(count_o), 10);
    @(negedge clk);
    chk("R5 pulse one cycle", 32'(rst_req_o), 0);
    s = nxt(s);
    clr(s);
    chk("R9 sequence held", 32'(rst_req_o), 0);
    cur_req = "R10";
    wr_cfg(4'b0000);
    wr_load(16'd3);
    wr_seed(8'h99);
    ticks(10);
    chk("R10 still running", 32'(count_o), 0);
    cur_req = "R5";
    tick_i = 1; @(negedge clk); tick_i = 0;
    chk("R5 reset pulse", 32'(rst_req_o), 1);
    chk("R10 reload kept", 32'(count_o), 10);
    @(negedge clk);
    chk("R5 single cycle", 32'(rst_req_o), 0);
    cur_req = "R10";
    s = nxt(s);
    clr(s);
    chk("R10 seed kept", 32'(rst_req_o), 0);

    // R6 R7 NMI action, non-secure
    do_reset();
    cur_req = "R6";
    wr_load(16'd4);
    wr_cfg(4'b1011);
    ticks(5);
    chk("R6 nmi set", 32'(nmi_o), 1);
    ticks(2);
    chk("R6 nmi held", 32'(nmi_o), 1);
    cur_req = "R7";
    clr(8'h00);
    chk("R7 nmi cleared", 32'(nmi_o), 0);
    chk("R7 reload", 32'(count_o), 4);
    ticks(1);
    tick_i = 1; clr_we = 1; clr_data = 8'hC3; @(negedge clk);
    tick_i = 0; clr_we = 0;
    chk("R7 clear beats tick", 32'(count_o), 4);

    // R1 R8 R9 reset seed, secure with NMI action
    do_reset();
    cur_req = "R8";
    wr_cfg(4'b1111);
    clr(8'h5A);
    chk("R1 reset seed", 32'(nmi_o), 0);
    s = 8'h5A;
    for (int k = 0; k < 6; k++) begin
      s = nxt(s);
      ticks(1);
      clr(s);
      chk("R8 chain", 32'(count_o), 32'hFFFF);
    end
    cur_req = "R9";
    clr(~nxt(s));
    chk("R9 nmi on wrong", 32'(nmi_o), 1);
    s = nxt(s);
    clr(s);
    chk("R9 right value clears", 32'(nmi_o), 0);

    @(negedge clk);
    summary();
  end

endmodule